// File: doc/BRIEF.md
# Serial Six-Bit Cyclic Check Generator and Checker

This block computes a 6-bit cyclic check over a fixed 15-bit codeword that arrives one bit per clock, most significant bit first. Each incoming bit is XORed with the top bit of a 6-stage feedback shift register. That feedback value enters stage 0 and is also folded into the shifts that land in stages 2 and 5. This gives the generator x^6 + x^5 + x^2 + 1. The bits of the register move toward the high end on every accepted bit.

A host pulses `start`, then presents the 15 codeword bits on `din` with `din_vld` high. Cycles with `din_vld` low may fall anywhere in a frame. One cycle after the fifteenth accepted bit, `done` pulses and `chk_out` holds the finished check value. The value stays there until the next `start`. On the receive side the host can present the check word that arrived with the codeword on `rx_chk`, qualified by `rx_chk_vld`. In that case `mismatch` rises together with `done` if the two check values differ.

Top module: `pcg_serial`

## Requirements
- R1: While reset is asserted and immediately after it, `chk_out` is all zeros and both `done` and `mismatch` are low.
- R2: A cycle with `start` high clears the check register and the bit counter. Any `din` bit offered in that same cycle is not taken, so a frame that begins after a `start` gives a result that does not depend on an earlier partial frame.
- R3: Bits enter in the order codeword bit 14 first, down to bit 0. After 15 accepted bits, `chk_out[k]` equals the XOR of these codeword bits: k=5: {14,12,10,9,6,5,4,2,1,0}; k=4: {14,13,12,11,10,8,6,3,2}; k=3: {13,12,11,10,9,7,5,2,1}; k=2: {12,11,10,9,8,6,4,1,0}; k=1: {14,12,11,8,7,6,4,3,2,1}; k=0: {13,11,10,7,6,5,3,2,1,0}.
- R4: `done` is high for exactly one cycle, in the cycle right after the clock edge that takes the fifteenth accepted bit.
- R5: A cycle with `din_vld` low and `start` low changes neither `chk_out` nor the bit count, so idle cycles inside a frame leave its result unchanged.
- R6: Once 15 bits have been accepted, further bits with `din_vld` high are ignored until the next `start`. `chk_out` keeps its value and `done` does not pulse again.
- R7: `mismatch` is high only while `done` and `rx_chk_vld` are both high and `rx_chk` differs from `chk_out`. It is low in every other case.
- R8: Every error pattern of one, two or three flipped codeword bits, and every pattern with an odd number of flipped bits, gives a check value different from the one of the error-free codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the check register and bit counter for a new frame |
| din | input | 1 | Serial codeword bit, most significant first |
| din_vld | input | 1 | Qualifies `din` |
| rx_chk | input | 6 | Received check word to compare against |
| rx_chk_vld | input | 1 | `rx_chk` is present and should be compared |
| chk_out | output | 6 | Computed check value |
| done | output | 1 | One-cycle pulse: frame complete, `chk_out` final |
| mismatch | output | 1 | Received check differs from computed value (with `done`) |

## Verification
A sweep of 4096 codewords compares the serial result with the six XOR equations. The sweep varies every high-order bit together with all low-order combinations, so a mistake in any single tap or shift path shows up. The same words are also fed with idle gaps at different spacings, which separates a design that shifts on every clock from one that honours the valid qualifier. Error patterns of weight one to three, and a set of weight-five patterns, are applied to fixed base words. These show whether the taps give the required detection rather than an equation match alone. Further tests cover surplus bits after a full frame, a restart partway through a frame, and a received check word that is right, wrong, or not qualified. These tell the counter's saturation, the clearing on `start`, and the gating of `mismatch` apart from the core arithmetic.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned CHK_W     = 6;
  localparam int unsigned FRAME_LEN = 15;
  // Generator coefficients x^0..x^5 (x^6 implicit): x^6 + x^5 + x^2 + 1
  localparam logic [CHK_W-1:0] GEN_POLY = 6'b100101;
endpackage

// File: rtl/pcg_lfsr.sv
module pcg_lfsr #(
  parameter int unsigned            W    = pcg_pkg::CHK_W,
  parameter logic [W-1:0]           POLY = pcg_pkg::GEN_POLY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] chk
);
  logic [W-1:0] chk_q;
  logic [W-1:0] shifted;
  logic [W-1:0] chk_d;
  logic         fb;

  assign fb = din ^ chk_q[W-1];

  // Stage 0 takes the feedback; every other stage takes its lower neighbour,
  // with the feedback folded in where the generator has a coefficient.
  assign shifted[0] = POLY[0] & fb;
  for (genvar i = 1; i < W; i++) begin : g_stage
    assign shifted[i] = chk_q[i-1] ^ (POLY[i] & fb);
  end

  always_comb begin
    chk_d = chk_q;
    if (clr) begin
      chk_d = '0;
    end else if (step) begin
      chk_d = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= '0;
    end else begin
      chk_q <= chk_d;
    end
  end

  assign chk = chk_q;
endmodule

// File: rtl/pcg_count.sv
module pcg_count #(
  parameter int unsigned LEN   = pcg_pkg::FRAME_LEN,
  localparam int unsigned CW   = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din_vld,
  output logic step,
  output logic done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          full;

  assign full = (cnt_q == CW'(LEN));
  assign step = din_vld && !start && !full;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == CW'(LEN - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/pcg_cmp.sv
module pcg_cmp #(
  parameter int unsigned W = pcg_pkg::CHK_W
) (
  input  logic [W-1:0] calc,
  input  logic [W-1:0] rcvd,
  input  logic         rcvd_vld,
  input  logic         done,
  output logic         mismatch
);
  assign mismatch = done && rcvd_vld && (calc != rcvd);
endmodule

// File: rtl/pcg_serial.sv
module pcg_serial #(
  parameter int unsigned W   = pcg_pkg::CHK_W,
  parameter int unsigned LEN = pcg_pkg::FRAME_LEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         din,
  input  logic         din_vld,
  input  logic [W-1:0] rx_chk,
  input  logic         rx_chk_vld,
  output logic [W-1:0] chk_out,
  output logic         done,
  output logic         mismatch
);
  logic step;

  pcg_count #(.LEN(LEN)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .din_vld (din_vld),
    .step    (step),
    .done    (done)
  );

  pcg_lfsr #(.W(W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .step  (step),
    .din   (din),
    .chk   (chk_out)
  );

  pcg_cmp #(.W(W)) u_cmp (
    .calc     (chk_out),
    .rcvd     (rx_chk),
    .rcvd_vld (rx_chk_vld),
    .done     (done),
    .mismatch (mismatch)
  );
endmodule

// File: rtl/pcg_serial_chk.sv
module pcg_serial_chk #(
  parameter int unsigned W = pcg_pkg::CHK_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         din_vld,
  input logic [W-1:0] rx_chk,
  input logic         rx_chk_vld,
  input logic [W-1:0] chk_out,
  input logic         done,
  input logic         mismatch
);
  // R2: start leaves a clear register and no completion
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (chk_out == '0 && !done));

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: completion only follows an offered bit without start
  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(din_vld) && !$past(start)));

  // R5: idle cycles hold the check value
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!din_vld && !start) |=> $stable(chk_out));

  // R6: after completion the value holds until a new start
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(chk_out));

  // R7: mismatch gated by completion and qualifier
  p_mismatch_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> (done && rx_chk_vld && rx_chk != chk_out));
endmodule

bind pcg_serial pcg_serial_chk #(.W(W)) u_pcg_serial_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .din_vld    (din_vld),
  .rx_chk     (rx_chk),
  .rx_chk_vld (rx_chk_vld),
  .chk_out    (chk_out),
  .done       (done),
  .mismatch   (mismatch)
);

// File: tb/tb_pcg_serial.sv
module tb_pcg_serial;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, din, din_vld, rx_chk_vld;
  logic [5:0] rx_chk;
  logic [5:0] chk_out;
  logic       done, mismatch;

  int total = 0;
  int bad   = 0;
  logic [5:0] got_chk;
  logic       got_done, got_mis;

  always #5 clk = ~clk;

  pcg_serial dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .din_vld(din_vld),
    .rx_chk(rx_chk), .rx_chk_vld(rx_chk_vld),
    .chk_out(chk_out), .done(done), .mismatch(mismatch)
  );

  function automatic logic [5:0] ref_chk(input logic [14:0] m);
    ref_chk[5] = m[14]^m[12]^m[10]^m[9]^m[6]^m[5]^m[4]^m[2]^m[1]^m[0];
    ref_chk[4] = m[14]^m[13]^m[12]^m[11]^m[10]^m[8]^m[6]^m[3]^m[2];
    ref_chk[3] = m[13]^m[12]^m[11]^m[10]^m[9]^m[7]^m[5]^m[2]^m[1];
    ref_chk[2] = m[12]^m[11]^m[10]^m[9]^m[8]^m[6]^m[4]^m[1]^m[0];
    ref_chk[1] = m[14]^m[12]^m[11]^m[8]^m[7]^m[6]^m[4]^m[3]^m[2]^m[1];
    ref_chk[0] = m[13]^m[11]^m[10]^m[7]^m[6]^m[5]^m[3]^m[2]^m[1]^m[0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pulse start, feed 15 bits MSB first, with an idle cycle before every bit
  // whose index is a multiple of gap (gap 0: no idles). Sample after last edge.
  task automatic run_frame(input logic [14:0] w, input int gap,
                           input logic [5:0] rx, input logic rxv);
    @(negedge clk); start = 1'b1; din_vld = 1'b0;
    @(negedge clk); start = 1'b0; rx_chk = rx; rx_chk_vld = rxv;
    for (int b = 14; b >= 0; b--) begin
      if (gap != 0 && (b % gap) == 0) begin
        din_vld = 1'b0; din = ~w[b];
        @(negedge clk);
      end
      din = w[b]; din_vld = 1'b1;
      @(negedge clk);
    end
    din_vld = 1'b0;
    got_chk = chk_out; got_done = done; got_mis = mismatch;
  endtask

  task automatic t_reset;
    check("R1 chk_out", 32'(chk_out), 32'h0);
    check("R1 done", 32'(done), 32'h0);
    check("R1 mismatch", 32'(mismatch), 32'h0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 4096; i++) begin
      logic [14:0] w;
      w = 15'(i * 8 + (i & 7));
      run_frame(w, 0, 6'h0, 1'b0);
      check("R3 sweep", 32'(got_chk), 32'(ref_chk(w)));
      check("R4 done", 32'(got_done), 32'h1);
    end
  endtask

  task automatic t_done_pulse;
    run_frame(15'h2A5C, 0, 6'h0, 1'b0);
    check("R4 done high", 32'(got_done), 32'h1);
    @(negedge clk);
    check("R4 done single", 32'(done), 32'h0);
    check("R4 value held", 32'(chk_out), 32'(ref_chk(15'h2A5C)));
  endtask

  task automatic t_gaps;
    logic [5:0] mid;
    for (int g = 2; g <= 5; g++) begin
      logic [14:0] w;
      w = 15'h1234 ^ 15'(g * 1109);
      run_frame(w, g, 6'h0, 1'b0);
      check("R5 gaps", 32'(got_chk), 32'(ref_chk(w)));
      check("R5 gap done", 32'(got_done), 32'h1);
    end
    // mid-frame hold across idle cycles with din toggling
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int b = 0; b < 5; b++) begin
      din = b[0]; din_vld = 1'b1; @(negedge clk);
    end
    din_vld = 1'b0; mid = chk_out;
    for (int k = 0; k < 3; k++) begin
      din = k[0]; @(negedge clk);
    end
    check("R5 idle hold", 32'(chk_out), 32'(mid));
  endtask

  task automatic t_overrun;
    logic [5:0] r;
    r = ref_chk(15'h5A0F);
    run_frame(15'h5A0F, 0, 6'h0, 1'b0);
    check("R6 base", 32'(got_chk), 32'(r));
    for (int k = 0; k < 5; k++) begin
      din = k[0]; din_vld = 1'b1; @(negedge clk);
      check("R6 no redone", 32'(done), 32'h0);
    end
    din_vld = 1'b0;
    check("R6 held", 32'(chk_out), 32'(r));
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 cleared", 32'(chk_out), 32'h0);
  endtask

  task automatic t_restart;
    // partial frame, then start offered together with a valid bit
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int b = 0; b < 7; b++) begin
      din = 1'b1; din_vld = 1'b1; @(negedge clk);
    end
    start = 1'b1; din = 1'b1; din_vld = 1'b1;
    @(negedge clk); start = 1'b0; din_vld = 1'b0;
    check("R2 start clears", 32'(chk_out), 32'h0);
    for (int b = 14; b >= 0; b--) begin
      din = b[0] ^ b[2]; din_vld = 1'b1; @(negedge clk);
    end
    din_vld = 1'b0;
    begin
      logic [14:0] w;
      for (int b = 0; b < 15; b++) w[b] = b[0] ^ b[2];
      check("R2 restart result", 32'(chk_out), 32'(ref_chk(w)));
      check("R2 restart done", 32'(done), 32'h1);
    end
  endtask

  task automatic t_mismatch;
    logic [5:0] r;
    r = ref_chk(15'h6B3D);
    run_frame(15'h6B3D, 0, r, 1'b1);
    check("R7 match", 32'(got_mis), 32'h0);
    run_frame(15'h6B3D, 0, r ^ 6'h10, 1'b1);
    check("R7 differ", 32'(got_mis), 32'h1);
    @(negedge clk);
    check("R7 low after done", 32'(mismatch), 32'h0);
    run_frame(15'h6B3D, 0, r ^ 6'h01, 1'b0);
    check("R7 unqualified", 32'(got_mis), 32'h0);
    rx_chk_vld = 1'b0;
  endtask

  task automatic t_detect;
    logic [14:0] bases [2] = '{15'h0000, 15'h4D71};
    for (int bi = 0; bi < 2; bi++) begin
      logic [5:0] good;
      run_frame(bases[bi], 0, 6'h0, 1'b0);
      good = got_chk;
      for (int e = 1; e < 32768; e++) begin
        int n;
        n = $countones(15'(e));
        if (n <= 3 || (n == 5 && (e % 29) == 0)) begin
          run_frame(bases[bi] ^ 15'(e), 0, 6'h0, 1'b0);
          total++;
          if (got_chk == good) begin
            bad++;
            $display("FAIL R8: pattern %0h undetected actual=%0h expected!=%0h",
                     e, got_chk, good);
          end
        end
      end
    end
  endtask

  initial begin
    start = 1'b0; din = 1'b0; din_vld = 1'b0;
    rx_chk = '0; rx_chk_vld = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_done_pulse();
    t_gaps();
    t_overrun();
    t_restart();
    t_mismatch();
    t_detect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule